// File: doc/BRIEF.md
# Coprocessor Instruction Class Decoder

This block classifies a floating-point coprocessor instruction from its first two 16-bit words: the opcode word and the extension word. A front end that has fetched both words presents them with a valid strobe. The decoder reports which handler the instruction belongs to, whether it is illegal, whether a branch carries a 32-bit displacement, the 6-bit arithmetic sub-opcode, and the base instruction length in bytes. The front end uses these results to dispatch the instruction and to advance its fetch pointer.

Decoding runs on two levels. The family field of the opcode word first picks the generic group, the conditional group, or a branch. Inside the generic group, a prioritised table of mask and match patterns applied to the extension word picks the sub-operation. The effective address and any operands are not examined. A parameter chooses between a registered result stage, loaded only while the strobe is high, and a purely combinational path.

Top module: `cpdec_top`

## Requirements
- R1: An opcode word whose bits 15..12 are not all ones sets illegal_o.
- R2: Opcode bits 11..9 must equal the parameter COP_ID, which defaults to 1. Any other value sets illegal_o.
- R3: Opcode bits 8..6 give the family. Value 0 is generic. Value 1 is the conditional group and sets class_o[7]. Values 2 and 3 are branches and set class_o[6]. Values 4 to 7 set illegal_o.
- R4: In the generic family, extension bits 15..14 equal to 11 set class_o[0] (register-list move). Bits 15..14 equal to 10 set class_o[1] (control-register move).
- R5: In the generic family, extension bits 15..13 equal to 011 set class_o[2] (store to memory). Otherwise, extension bits 15..10 equal to 010111 set class_o[3] (constant load).
- R6: In the generic family, an extension word that equals 0x0026 after masking with 0xA07F sets class_o[4] (scale). Any extension word not matched sooner sets class_o[5] (arithmetic). Patterns are tried in the order R4, R5, R6.
- R7: At most one bit of class_o is set. While illegal_o is set, class_o is zero and long_disp_o is low.
- R8: length_o is 4. A legal family-3 branch sets long_disp_o and gives length_o 6.
- R9: arith_op_o equals bits 5..0 of the extension word presented with the strobe.
- R10: With OUT_REG=1, the results appear one clock after a cycle with valid_i high, and valid_o is high in that clock only. The results hold while valid_i is low. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction words are valid |
| opcode_i | input | 16 | First instruction word |
| ext_i | input | 16 | Extension word |
| valid_o | output | 1 | Decode result valid |
| class_o | output | 8 | One-hot class: 0 reglist, 1 ctrl, 2 store, 3 const, 4 scale, 5 arith, 6 branch, 7 conditional |
| illegal_o | output | 1 | Instruction is illegal |
| long_disp_o | output | 1 | Branch has a 32-bit displacement |
| arith_op_o | output | 6 | Arithmetic sub-opcode |
| length_o | output | 4 | Base length in bytes |

## Verification
The assertions assume two things about the inputs. First, valid_i is low throughout reset. Second, opcode_i and ext_i carry known values in every cycle in which valid_i is high, because a result that holds on its registered copy would otherwise be undefined. The bench drives every input on the falling edge, keeps the strobe low until after reset is released, and gives each instruction exactly one strobe cycle. To exercise the hold behaviour, it then changes the words while the strobe is low.

// File: rtl/cpdec_pkg.sv
package cpdec_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SUB_W  = 6;
  localparam int unsigned LEN_W  = 4;
  localparam int unsigned GEN_N  = 6;
  localparam int unsigned CLS_N  = GEN_N + 2;

  localparam int unsigned CLS_BRANCH = GEN_N;
  localparam int unsigned CLS_COND   = GEN_N + 1;

  localparam logic [LEN_W-1:0] LEN_BASE = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_LONG = LEN_W'(6);

  // Family field values
  localparam logic [2:0] FAM_GENERIC = 3'd0;
  localparam logic [2:0] FAM_COND    = 3'd1;
  localparam logic [2:0] FAM_BR16    = 3'd2;
  localparam logic [2:0] FAM_BR32    = 3'd3;

  // Generic sub-decode, highest priority first; last entry always hits
  localparam logic [WORD_W-1:0] GEN_MASK  [GEN_N] =
    '{16'hC000, 16'hC000, 16'hE000, 16'hFC00, 16'hA07F, 16'h0000};
  localparam logic [WORD_W-1:0] GEN_MATCH [GEN_N] =
    '{16'hC000, 16'h8000, 16'h6000, 16'h5C00, 16'h0026, 16'h0000};

  typedef struct packed {
    logic [CLS_N-1:0] cls;
    logic             illegal;
    logic             long_disp;
    logic [SUB_W-1:0] sub_op;
    logic [LEN_W-1:0] len_bytes;
  } dec_t;
endpackage

// File: rtl/cpdec_opword.sv
module cpdec_opword
  import cpdec_pkg::*;
#(
  parameter logic [2:0] COP_ID = 3'd1
) (
  input  logic [WORD_W-1:0] opcode_i,
  output logic              legal_o,
  output logic              fam_generic_o,
  output logic              fam_cond_o,
  output logic              fam_branch_o,
  output logic              fam_long_o
);
  logic       prefix_ok, id_ok, type_ok;
  logic [2:0] fam;

  assign fam       = opcode_i[8:6];
  assign prefix_ok = &opcode_i[15:12];
  assign id_ok     = (opcode_i[11:9] == COP_ID);
  // save/restore and reserved families are rejected
  assign type_ok   = ~fam[2];
  assign legal_o   = prefix_ok & id_ok & type_ok;

  assign fam_generic_o = (fam == FAM_GENERIC);
  assign fam_cond_o    = (fam == FAM_COND);
  assign fam_branch_o  = (fam == FAM_BR16) | (fam == FAM_BR32);
  assign fam_long_o    = (fam == FAM_BR32);
endmodule

// File: rtl/cpdec_extword.sv
module cpdec_extword
  import cpdec_pkg::*;
(
  input  logic [WORD_W-1:0] ext_i,
  output logic [GEN_N-1:0]  gen_cls_o
);
  logic [GEN_N-1:0] hit;

  for (genvar g = 0; g < GEN_N; g++) begin : g_pat
    assign hit[g] = ((ext_i & GEN_MASK[g]) == GEN_MATCH[g]);
  end

  always_comb begin
    logic taken;
    taken     = 1'b0;
    gen_cls_o = '0;
    for (int i = 0; i < GEN_N; i++) begin
      if (hit[i] && !taken) begin
        gen_cls_o[i] = 1'b1;
        taken        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpdec_outstage.sv
module cpdec_outstage
  import cpdec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  dec_t d_i,
  output dec_t d_o,
  output logic valid_o
);
  if (OUT_REG) begin : g_reg
    dec_t d_q;
    logic v_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= valid_i;
        if (valid_i) d_q <= d_i;
      end
    end

    assign d_o     = d_q;
    assign valid_o = v_q;

    // R10
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    // R10
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(d_o)));
  end else begin : g_comb
    assign d_o     = d_i;
    assign valid_o = valid_i;
  end
endmodule

// File: rtl/cpdec_top.sv
module cpdec_top
  import cpdec_pkg::*;
#(
  parameter logic [2:0] COP_ID  = 3'd1,
  parameter bit         OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] opcode_i,
  input  logic [WORD_W-1:0] ext_i,
  output logic              valid_o,
  output logic [CLS_N-1:0]  class_o,
  output logic              illegal_o,
  output logic              long_disp_o,
  output logic [SUB_W-1:0]  arith_op_o,
  output logic [LEN_W-1:0]  length_o
);
  logic             legal, fam_gen, fam_cond, fam_br, fam_long;
  logic [GEN_N-1:0] gen_cls;
  dec_t             dec_d, dec_q;

  cpdec_opword #(.COP_ID(COP_ID)) i_opword (
    .opcode_i      (opcode_i),
    .legal_o       (legal),
    .fam_generic_o (fam_gen),
    .fam_cond_o    (fam_cond),
    .fam_branch_o  (fam_br),
    .fam_long_o    (fam_long)
  );

  cpdec_extword i_extword (
    .ext_i     (ext_i),
    .gen_cls_o (gen_cls)
  );

  always_comb begin
    dec_d                 = '0;
    dec_d.illegal         = ~legal;
    dec_d.sub_op          = ext_i[SUB_W-1:0];
    dec_d.len_bytes       = LEN_BASE;
    if (legal) begin
      dec_d.cls[GEN_N-1:0]  = fam_gen ? gen_cls : '0;
      dec_d.cls[CLS_BRANCH] = fam_br;
      dec_d.cls[CLS_COND]   = fam_cond;
      dec_d.long_disp       = fam_long;
      if (fam_long) dec_d.len_bytes = LEN_LONG;
    end
  end

  cpdec_outstage #(.OUT_REG(OUT_REG)) i_outstage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .d_i     (dec_d),
    .d_o     (dec_q),
    .valid_o (valid_o)
  );

  assign class_o     = dec_q.cls;
  assign illegal_o   = dec_q.illegal;
  assign long_disp_o = dec_q.long_disp;
  assign arith_op_o  = dec_q.sub_op;
  assign length_o    = dec_q.len_bytes;

  // R7
  cls_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(class_o));
  // R7
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (class_o == '0 && !long_disp_o));
  // R8
  len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (length_o == (long_disp_o ? LEN_LONG : LEN_BASE)));
  // R8
  long_is_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_disp_o |-> class_o[CLS_BRANCH]);
  // R7
  legal_has_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |-> ($countones(class_o) == 1));
endmodule

// File: tb/test_cpdec_top.sv
`timescale 1ns/1ps
module test_cpdec_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [15:0] ext_i = '0;
  logic        valid_o;
  logic [7:0]  class_o;
  logic        illegal_o;
  logic        long_disp_o;
  logic [5:0]  arith_op_o;
  logic [3:0]  length_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [7:0] C_RL = 8'h01, C_CT = 8'h02, C_ST = 8'h04, C_CN = 8'h08,
                         C_SC = 8'h10, C_AR = 8'h20, C_BR = 8'h40, C_CD = 8'h80;

  always #2.5 clk_i = ~clk_i;

  cpdec_top i_cpdec_top (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .ext_i,
    .valid_o, .class_o, .illegal_o, .long_disp_o, .arith_op_o, .length_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one strobe cycle, sample after the register has loaded
  task automatic run(input string req, input logic [15:0] op, input logic [15:0] ex,
                     input logic [7:0] e_cls, input logic e_ill, input logic e_long,
                     input logic [3:0] e_len);
    @(negedge clk_i);
    opcode_i = op; ext_i = ex; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, "valid_o", int'(valid_o), 1);
    chk(req, "class_o", int'(class_o), int'(e_cls));
    chk(req, "illegal_o", int'(illegal_o), int'(e_ill));
    chk(req, "long_disp_o", int'(long_disp_o), int'(e_long));
    chk(req, "length_o", int'(length_o), int'(e_len));
  endtask

  task automatic t_reset();
    chk("R10", "reset valid_o", int'(valid_o), 0);
    chk("R10", "reset class_o", int'(class_o), 0);
    chk("R10", "reset illegal_o", int'(illegal_o), 0);
    chk("R10", "reset length_o", int'(length_o), 0);
  endtask

  task automatic t_prefix();
    run("R1", 16'hE200, 16'h0022, 8'h00, 1'b1, 1'b0, 4'd4);
    run("R1", 16'h72C0, 16'h0000, 8'h00, 1'b1, 1'b0, 4'd4);
  endtask

  task automatic t_cop_id();
    run("R2", 16'hF400, 16'h0022, 8'h00, 1'b1, 1'b0, 4'd4);
    run("R2", 16'hF0C0, 16'h0000, 8'h00, 1'b1, 1'b0, 4'd4);
  endtask

  task automatic t_family();
    run("R3", 16'hF240, 16'h0001, C_CD, 1'b0, 1'b0, 4'd4);
    run("R3", 16'hF280, 16'hC000, C_BR, 1'b0, 1'b0, 4'd4);
    for (int f = 4; f < 8; f++)
      run("R3", 16'hF200 | 16'(f << 6), 16'h0022, 8'h00, 1'b1, 1'b0, 4'd4);
  endtask

  task automatic t_moves();
    run("R4", 16'hF210, 16'hE0FF, C_RL, 1'b0, 1'b0, 4'd4);
    run("R4", 16'hF200, 16'hE026, C_RL, 1'b0, 1'b0, 4'd4);
    run("R4", 16'hF23C, 16'h8026, C_CT, 1'b0, 1'b0, 4'd4);
  endtask

  task automatic t_store_const();
    run("R5", 16'hF200, 16'h6000, C_ST, 1'b0, 1'b0, 4'd4);
    run("R5", 16'hF200, 16'h5C0F, C_CN, 1'b0, 1'b0, 4'd4);
    // constant pattern outranks scale mask
    run("R5", 16'hF200, 16'h5C26, C_CN, 1'b0, 1'b0, 4'd4);
  endtask

  task automatic t_scale_arith();
    run("R6", 16'hF200, 16'h0026, C_SC, 1'b0, 1'b0, 4'd4);
    run("R6", 16'hF200, 16'h4026, C_SC, 1'b0, 1'b0, 4'd4);
    run("R6", 16'hF200, 16'h1F26, C_SC, 1'b0, 1'b0, 4'd4);
    run("R6", 16'hF200, 16'h2026, C_AR, 1'b0, 1'b0, 4'd4);
    run("R6", 16'hF200, 16'h0027, C_AR, 1'b0, 1'b0, 4'd4);
    run("R6", 16'hF200, 16'h5800, C_AR, 1'b0, 1'b0, 4'd4);
  endtask

  task automatic t_branch_len();
    run("R8", 16'hF2C1, 16'h1234, C_BR, 1'b0, 1'b1, 4'd6);
    run("R8", 16'hF281, 16'hFFFE, C_BR, 1'b0, 1'b0, 4'd4);
    run("R7", 16'hF6C0, 16'h0000, 8'h00, 1'b1, 1'b0, 4'd4);
  endtask

  task automatic t_subop();
    run("R9", 16'hF200, 16'h0438, C_AR, 1'b0, 1'b0, 4'd4);
    chk("R9", "arith_op_o", int'(arith_op_o), 'h38);
    run("R9", 16'hF200, 16'h1C1A, C_AR, 1'b0, 1'b0, 4'd4);
    chk("R9", "arith_op_o", int'(arith_op_o), 'h1A);
  endtask

  task automatic t_hold();
    run("R10", 16'hF2C0, 16'h0000, C_BR, 1'b0, 1'b1, 4'd6);
    @(negedge clk_i);
    opcode_i = 16'hE000; ext_i = 16'h0022;
    @(negedge clk_i);
    chk("R10", "hold valid_o", int'(valid_o), 0);
    chk("R10", "hold class_o", int'(class_o), int'(C_BR));
    chk("R10", "hold illegal_o", int'(illegal_o), 0);
    chk("R10", "hold length_o", int'(length_o), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_prefix();
    t_cop_id();
    t_family();
    t_moves();
    t_store_const();
    t_scale_arith();
    t_branch_len();
    t_subop();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule